// File: doc/BRIEF.md
# Card Data FIFO Engine

This block moves data between a host-side queue of 32-bit words and a byte-wide card data path. It works in either direction. In the receive direction, bytes taken from the card are packed into words, with the first byte in the lowest lane, and then pushed into the queue for the host to pop. In the transmit direction, words that the host pushes are split into bytes, lowest lane first, and handed to the card. A 16-bit byte countdown loaded at start governs the transfer. The countdown may end part way through a word.

A transfer begins with a one-cycle start pulse that carries a direction and a byte length. The engine raises `busy` and moves at most one byte per clock. When the countdown reaches zero it raises two sticky completion flags. It drops `busy` by itself once the countdown is zero and the queue has drained. While busy, it shows a set of queue level flags for the active direction only.

Back-pressure follows valid/ready rules. A byte or word moves on a clock edge where both valid and ready are high. `card_rd_ready` is low while the queue is full or the countdown is zero, so a card holding `card_rd_valid` waits. `card_wr_valid` is low while the engine has no byte to send, and the engine holds the byte until `card_wr_ready` accepts it. `push_ready` is low whenever the host may not push. The host pop side is a plain strobe with a combinational head word.

Top module: `card_fifo_engine`

## Requirements
- R1: After reset, `busy`, every level flag, both completion flags, `pop_err`, `byte_count`, `word_count`, `card_rd_ready`, `card_wr_valid`, `push_ready` and `pop_data` are all zero, and the latched direction is transmit.
- R2: A `start` pulse while idle does four things: it loads the countdown from `start_len`, latches `start_dir` (1 = receive, 0 = transmit), raises `busy` on the next edge, and clears the completion flags and `pop_err`. A `start` pulse while busy has no effect.
- R3: In receive, `card_rd_ready` is high only while busy, the countdown is nonzero and the queue (16 words) is not full. Accepted bytes are packed little-endian: byte 4j+b of the transfer lands in bits 8b+7:8b of word j.
- R4: In receive, when the countdown ends part way through a word, that partial word is still pushed, with its unfilled upper lanes zero.
- R5: In transmit, the engine takes words from the queue and offers their bytes in lanes 7:0, 15:8, 23:16, 31:24 order. It sends exactly the loaded number of bytes. Unsent lanes of the final word are discarded. `card_wr_valid` is low while the queue is empty and no bytes of the current word remain.
- R6: At most one byte moves per clock, and the countdown drops by exactly one for each byte moved.
- R7: On the first edge where the engine is busy with a zero countdown, the data-end and block-end flags are set. They stay set until the next accepted start.
- R8: `busy` clears itself on the edge after the countdown is zero and the queue is empty. It stays high while received words remain unread.
- R9: While busy in receive, the receive flags are shown. `rx_empty` means 0 words, `rx_avail` more than 0, `rx_half_full` 8 or more, `rx_full` 16, and `rx_active` is high. While busy in transmit, the transmit flags are shown in the same way, except that `tx_half_empty` means 8 or fewer words. The flags of the other direction, and all flags when idle, are zero.
- R10: `word_count` equals (`byte_count` + 3) >> 2.
- R11: `push_ready` is high only in transmit, while busy, with a nonzero countdown and a non-full queue. A push offered while it is low is ignored.
- R12: With receive latched, `pop_data` shows the head word and `pop_req` removes it. A `pop_req` on an empty queue returns zero and sets sticky `pop_err` until the next start. A `pop_req` with transmit latched is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only while idle |
| start_dir | input | 1 | Direction for the start: 1 receive, 0 transmit |
| start_len | input | 16 | Transfer length in bytes |
| push_valid | input | 1 | Host offers a word |
| push_ready | output | 1 | Engine accepts a host word |
| push_data | input | 32 | Host word to transmit |
| pop_req | input | 1 | Host removes the head word |
| pop_data | output | 32 | Head word, zero when empty or in transmit |
| pop_err | output | 1 | Sticky: pop attempted on an empty queue |
| card_rd_valid | input | 1 | Card has a byte ready |
| card_rd_ready | output | 1 | Engine takes the card byte |
| card_rd_data | input | 8 | Byte from the card |
| card_wr_valid | output | 1 | Engine offers a byte |
| card_wr_ready | input | 1 | Card accepts the byte |
| card_wr_data | output | 8 | Byte to the card |
| busy | output | 1 | Transfer enabled |
| byte_count | output | 16 | Remaining bytes |
| word_count | output | 15 | Remaining words, rounded up |
| data_end | output | 1 | Sticky: countdown reached zero |
| block_end | output | 1 | Sticky: block finished |
| rx_active | output | 1 | Receive flags valid |
| rx_empty | output | 1 | Receive queue empty |
| rx_avail | output | 1 | Receive queue holds data |
| rx_half_full | output | 1 | Receive queue at least half full |
| rx_full | output | 1 | Receive queue full |
| tx_active | output | 1 | Transmit flags valid |
| tx_empty | output | 1 | Transmit queue empty |
| tx_avail | output | 1 | Transmit queue holds data |
| tx_half_empty | output | 1 | Transmit queue at most half full |
| tx_full | output | 1 | Transmit queue full |

## Verification
The bench sweeps receive and transmit lengths of 1 to 9 bytes and some longer ones, so that every partial-word remainder is covered. If the packing, the lane order or the zero fill went wrong, the popped words or the byte log would differ from the arithmetic expectation. It steps the queue level one word at a time in both directions and checks each threshold at its boundary (0, 8 and 16 words). An off-by-one compare would then show a flag one word early or late, and a direction-select fault would show the wrong set. It stalls a full receive queue, then checks that the countdown freezes and that `busy` survives until the last unread word leaves. It also covers a zero-length start, a start issued while busy, a pop in transmit, and a pop from an empty queue, each of which must leave the observable state as the requirements say.

// File: rtl/cfe_pkg.sv
`timescale 1ns/1ps
package cfe_pkg;
  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } dir_e;

  typedef struct packed {
    logic active;
    logic empty;
    logic avail;
    logic full;
    logic half;
  } lvl_t;
endpackage

// File: rtl/cfe_word_fifo.sv
`timescale 1ns/1ps
module cfe_word_fifo #(
  parameter int W = 32,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [LW-1:0] lvl_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (push) wr_q <= bump(wr_q);
      if (pop)  rd_q <= bump(rd_q);
      lvl_q <= lvl_q + LW'(push) - LW'(pop);
    end
  end

  assign head  = mem[rd_q];
  assign level = lvl_q;
  assign full  = (lvl_q == LW'(DEPTH));
  assign empty = (lvl_q == '0);

  // R11: the gating upstream never lets a word in while full
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));
  // R12: the gating upstream never removes a word while empty
  p_no_underflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/cfe_byte_engine.sv
`timescale 1ns/1ps
module cfe_byte_engine
  import cfe_pkg::*;
#(
  parameter int W = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  input  logic             en,
  input  dir_e             dir,
  input  logic             fifo_full,
  input  logic             fifo_empty,
  input  logic [W-1:0]     fifo_head,
  input  logic             card_rd_valid,
  output logic             card_rd_ready,
  input  logic [7:0]       card_rd_data,
  output logic             card_wr_valid,
  input  logic             card_wr_ready,
  output logic [7:0]       card_wr_data,
  output logic             eng_push,
  output logic [W-1:0]     eng_push_data,
  output logic             eng_pop,
  output logic [LEN_W-1:0] cnt
);
  localparam int BPW    = W / 8;
  localparam int BW     = $clog2(BPW);
  localparam int LEFT_W = BW + 1;

  logic [LEN_W-1:0]  cnt_q;
  logic [W-1:0]      pack_q, hold_q, packed_next;
  logic [BW-1:0]     idx_q;
  logic [LEFT_W-1:0] left_q;
  logic rd_fire, wr_fire, have, last_byte, live;

  assign live      = en && (cnt_q != '0);
  assign last_byte = (cnt_q == LEN_W'(1));
  assign have      = (left_q != '0);

  assign card_rd_ready = live && (dir == DIR_RX) && !fifo_full;
  assign rd_fire       = card_rd_valid && card_rd_ready;
  assign packed_next   = pack_q | ({{(W-8){1'b0}}, card_rd_data} << {idx_q, 3'b000});
  assign eng_push      = rd_fire && ((idx_q == BW'(BPW - 1)) || last_byte);
  assign eng_push_data = packed_next;

  assign card_wr_valid = live && (dir == DIR_TX) && (have || !fifo_empty);
  assign card_wr_data  = have ? hold_q[7:0] : fifo_head[7:0];
  assign wr_fire       = card_wr_valid && card_wr_ready;
  assign eng_pop       = wr_fire && !have;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pack_q <= '0;
      hold_q <= '0;
      idx_q  <= '0;
      left_q <= '0;
    end else if (load) begin
      cnt_q  <= load_len;
      pack_q <= '0;
      hold_q <= '0;
      idx_q  <= '0;
      left_q <= '0;
    end else begin
      if (rd_fire) begin
        cnt_q <= cnt_q - 1'b1;
        if (eng_push) begin
          pack_q <= '0;
          idx_q  <= '0;
        end else begin
          pack_q <= packed_next;
          idx_q  <= idx_q + 1'b1;
        end
      end
      if (wr_fire) begin
        cnt_q <= cnt_q - 1'b1;
        if (last_byte) begin
          left_q <= '0;
        end else if (!have) begin
          hold_q <= fifo_head >> 8;
          left_q <= LEFT_W'(BPW - 1);
        end else begin
          hold_q <= hold_q >> 8;
          left_q <= left_q - 1'b1;
        end
      end
    end
  end

  assign cnt = cnt_q;

  // R6: each moved byte takes exactly one off the countdown
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_fire || wr_fire) && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R6: no byte moved, no change to the countdown
  p_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_fire && !wr_fire && !load) |=> $stable(cnt_q));
  // R5: the final byte discards any unsent lanes
  p_last_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && last_byte) |=> (left_q == '0 && !card_wr_valid));
  // R4: the last received byte always flushes the packing register
  p_tail_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && last_byte) |=> (idx_q == '0 && pack_q == '0));
endmodule

// File: rtl/cfe_level_flags.sv
`timescale 1ns/1ps
module cfe_level_flags
  import cfe_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  dir_e          dir,
  input  logic [LW-1:0] level,
  output lvl_t          rx,
  output lvl_t          tx
);
  localparam logic [LW-1:0] HALF = LW'(DEPTH / 2);
  localparam logic [LW-1:0] TOP  = LW'(DEPTH);

  logic on_rx, on_tx;
  assign on_rx = en && (dir == DIR_RX);
  assign on_tx = en && (dir == DIR_TX);

  always_comb begin
    rx.active = on_rx;
    rx.empty  = on_rx && (level == '0);
    rx.avail  = on_rx && (level != '0);
    rx.full   = on_rx && (level == TOP);
    rx.half   = on_rx && (level >= HALF);
    tx.active = on_tx;
    tx.empty  = on_tx && (level == '0);
    tx.avail  = on_tx && (level != '0);
    tx.full   = on_tx && (level == TOP);
    tx.half   = on_tx && (level <= HALF);
  end

  // R9: a full receive queue is also at least half full
  p_full_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx.full |-> (rx.half && rx.avail));
  // R9: a full transmit queue is never reported half empty
  p_tx_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx.full |-> !tx.half);
endmodule

// File: rtl/card_fifo_engine.sv
`timescale 1ns/1ps
module card_fifo_engine
  import cfe_pkg::*;
#(
  parameter int W = 32,
  parameter int DEPTH = 16,
  parameter int LEN_W = 16,
  localparam int BW = $clog2(W / 8),
  localparam int WC_W = LEN_W - BW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_dir,
  input  logic [LEN_W-1:0] start_len,
  input  logic             push_valid,
  output logic             push_ready,
  input  logic [W-1:0]     push_data,
  input  logic             pop_req,
  output logic [W-1:0]     pop_data,
  output logic             pop_err,
  input  logic             card_rd_valid,
  output logic             card_rd_ready,
  input  logic [7:0]       card_rd_data,
  output logic             card_wr_valid,
  input  logic             card_wr_ready,
  output logic [7:0]       card_wr_data,
  output logic             busy,
  output logic [LEN_W-1:0] byte_count,
  output logic [WC_W-1:0]  word_count,
  output logic             data_end,
  output logic             block_end,
  output logic             rx_active,
  output logic             rx_empty,
  output logic             rx_avail,
  output logic             rx_half_full,
  output logic             rx_full,
  output logic             tx_active,
  output logic             tx_empty,
  output logic             tx_avail,
  output logic             tx_half_empty,
  output logic             tx_full
);
  localparam int LW  = $clog2(DEPTH) + 1;
  localparam int BPW = W / 8;

  logic en_q, dend_q, bend_q, err_q, start_ok;
  dir_e dir_q;
  logic [LEN_W-1:0] cnt;
  logic [LW-1:0] level;
  logic f_push, f_pop, f_full, f_empty, host_push, host_pop;
  logic eng_push, eng_pop;
  logic [W-1:0] f_head, eng_push_data, f_wdata;
  logic [LEN_W:0] cnt_ext;
  lvl_t rx, tx;

  assign start_ok = start && !en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      dir_q  <= DIR_TX;
      dend_q <= 1'b0;
      bend_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (start_ok) begin
      en_q   <= 1'b1;
      dir_q  <= dir_e'(start_dir);
      dend_q <= 1'b0;
      bend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (en_q && cnt == '0) begin
        dend_q <= 1'b1;
        bend_q <= 1'b1;
        if (f_empty) en_q <= 1'b0;
      end
      if (pop_req && dir_q == DIR_RX && f_empty) err_q <= 1'b1;
    end
  end

  assign push_ready = en_q && (dir_q == DIR_TX) && (cnt != '0) && !f_full;
  assign host_push  = push_valid && push_ready;
  assign host_pop   = pop_req && (dir_q == DIR_RX) && !f_empty;
  assign f_push     = (dir_q == DIR_RX) ? eng_push : host_push;
  assign f_wdata    = (dir_q == DIR_RX) ? eng_push_data : push_data;
  assign f_pop      = (dir_q == DIR_RX) ? host_pop : eng_pop;
  assign pop_data   = (dir_q == DIR_RX && !f_empty) ? f_head : '0;

  cfe_word_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(f_push), .push_data(f_wdata),
    .pop(f_pop), .head(f_head), .level(level), .full(f_full), .empty(f_empty)
  );

  cfe_byte_engine #(.W(W), .LEN_W(LEN_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .load(start_ok), .load_len(start_len),
    .en(en_q), .dir(dir_q), .fifo_full(f_full), .fifo_empty(f_empty),
    .fifo_head(f_head), .card_rd_valid(card_rd_valid),
    .card_rd_ready(card_rd_ready), .card_rd_data(card_rd_data),
    .card_wr_valid(card_wr_valid), .card_wr_ready(card_wr_ready),
    .card_wr_data(card_wr_data), .eng_push(eng_push),
    .eng_push_data(eng_push_data), .eng_pop(eng_pop), .cnt(cnt)
  );

  cfe_level_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst_n(rst_n), .en(en_q), .dir(dir_q), .level(level),
    .rx(rx), .tx(tx)
  );

  assign cnt_ext    = {1'b0, cnt} + (LEN_W + 1)'(BPW - 1);
  assign word_count = cnt_ext[LEN_W:BW];
  assign byte_count = cnt;
  assign busy       = en_q;
  assign data_end   = dend_q;
  assign block_end  = bend_q;
  assign pop_err    = err_q;

  assign rx_active     = rx.active;
  assign rx_empty      = rx.empty;
  assign rx_avail      = rx.avail;
  assign rx_half_full  = rx.half;
  assign rx_full       = rx.full;
  assign tx_active     = tx.active;
  assign tx_empty      = tx.empty;
  assign tx_avail      = tx.avail;
  assign tx_half_empty = tx.half;
  assign tx_full       = tx.full;

  // R8: the engine only turns itself off with nothing left to move
  p_auto_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> ($past(cnt) == '0 && $past(f_empty)));
  // R7: completion flags persist until a new transfer is accepted
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dend_q && !start_ok) |=> dend_q);
  // R12: the empty-pop error persists until a new transfer is accepted
  p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !start_ok) |=> err_q);
  // R2: a start while busy leaves the latched direction alone
  p_busy_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && en_q) |=> $stable(dir_q));
endmodule

// File: tb/card_fifo_engine_bench.sv
`timescale 1ns/1ps
module card_fifo_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, start_dir = 1'b0;
  logic [15:0] start_len = '0;
  logic push_valid = 1'b0, push_ready;
  logic [31:0] push_data = '0;
  logic pop_req = 1'b0;
  logic [31:0] pop_data;
  logic pop_err;
  logic card_rd_valid = 1'b0, card_rd_ready;
  logic [7:0] card_rd_data;
  logic card_wr_valid, card_wr_ready = 1'b0;
  logic [7:0] card_wr_data;
  logic busy;
  logic [15:0] byte_count;
  logic [14:0] word_count;
  logic data_end, block_end;
  logic rx_active, rx_empty, rx_avail, rx_half_full, rx_full;
  logic tx_active, tx_empty, tx_avail, tx_half_empty, tx_full;

  int n_chk = 0;
  int n_err = 0;
  int rx_idx = 0;
  int tx_n = 0;
  logic [7:0] tx_log [512];

  always #2.5 clk = ~clk;

  card_fifo_engine u_card_fifo_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .start_dir(start_dir),
    .start_len(start_len), .push_valid(push_valid), .push_ready(push_ready),
    .push_data(push_data), .pop_req(pop_req), .pop_data(pop_data),
    .pop_err(pop_err), .card_rd_valid(card_rd_valid),
    .card_rd_ready(card_rd_ready), .card_rd_data(card_rd_data),
    .card_wr_valid(card_wr_valid), .card_wr_ready(card_wr_ready),
    .card_wr_data(card_wr_data), .busy(busy), .byte_count(byte_count),
    .word_count(word_count), .data_end(data_end), .block_end(block_end),
    .rx_active(rx_active), .rx_empty(rx_empty), .rx_avail(rx_avail),
    .rx_half_full(rx_half_full), .rx_full(rx_full), .tx_active(tx_active),
    .tx_empty(tx_empty), .tx_avail(tx_avail), .tx_half_empty(tx_half_empty),
    .tx_full(tx_full)
  );

  function automatic logic [7:0] rx_pat(input int k);
    return 8'((k * 29 + 3) & 255);
  endfunction

  function automatic logic [31:0] tx_word(input int j);
    logic [31:0] t;
    t = 32'(j + 7);
    return (t * 32'h0100_0193) ^ 32'hC3A5_5A3C;
  endfunction

  assign card_rd_data = rx_pat(rx_idx);

  always @(posedge clk) begin
    if (card_rd_valid && card_rd_ready) rx_idx <= rx_idx + 1;
    if (card_wr_valid && card_wr_ready) begin
      tx_log[tx_n] <= card_wr_data;
      tx_n <= tx_n + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_start(input logic d, input int len);
    @(negedge clk);
    start = 1'b1; start_dir = d; start_len = 16'(len);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic push_word(input logic [31:0] w);
    while (!push_ready) @(negedge clk);
    push_valid = 1'b1; push_data = w;
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  task automatic pop_word(input string req, input logic [31:0] exp);
    check(req, pop_data, exp);
    pop_req = 1'b1;
    @(negedge clk);
    pop_req = 1'b0;
  endtask

  task automatic wait_zero();
    for (int i = 0; i < 400 && byte_count != 0; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] rx_word(input int base, input int j, input int len);
    logic [31:0] w = '0;
    for (int b = 0; b < 4; b++)
      if (4 * j + b < len) w[8*b +: 8] = rx_pat(base + 4 * j + b);
    return w;
  endfunction

  task automatic rx_run(input int len);
    int base, nw;
    base = rx_idx;
    nw = (len + 3) / 4;
    do_start(1'b1, len);
    check("R2 load count", 32'(byte_count), 32'(len));
    check("R10 word count", 32'(word_count), 32'((len + 3) >> 2));
    card_rd_valid = 1'b1;
    repeat (len - 1) @(negedge clk);
    check("R6 one byte per cycle", 32'(byte_count), 32'd1);
    @(negedge clk);
    check("R6 count at zero", 32'(byte_count), 32'd0);
    card_rd_valid = 1'b0;
    @(negedge clk);
    check("R7 data end", 32'(data_end), 32'd1);
    check("R7 block end", 32'(block_end), 32'd1);
    check("R8 busy while words unread", 32'(busy), 32'd1);
    for (int j = 0; j < nw; j++) begin
      if (j == nw - 1 && (len % 4) != 0) pop_word("R4 partial word", rx_word(base, j, len));
      else pop_word("R3 packed word", rx_word(base, j, len));
    end
    check("R8 busy until edge after drain", 32'(busy), 32'd1);
    @(negedge clk);
    check("R8 auto disable", 32'(busy), 32'd0);
  endtask

  task automatic tx_run(input int len);
    int base, nw;
    base = tx_n;
    nw = (len + 3) / 4;
    do_start(1'b0, len);
    check("R10 word count tx", 32'(word_count), 32'((len + 3) >> 2));
    check("R5 no byte without data", 32'(card_wr_valid), 32'd0);
    for (int j = 0; j < nw; j++) push_word(tx_word(base + j));
    card_wr_ready = 1'b1;
    wait_zero();
    repeat (3) @(negedge clk);
    card_wr_ready = 1'b0;
    check("R5 exact byte total", 32'(tx_n - base), 32'(len));
    for (int k = 0; k < len; k++)
      check("R5 byte order", 32'(tx_log[base + k]), 32'(tx_word(base + k / 4) >> (8 * (k % 4))) & 32'hFF);
    check("R7 data end tx", 32'(data_end), 32'd1);
    check("R8 auto disable tx", 32'(busy), 32'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 counts", {byte_count, 1'b0, word_count}, 32'd0);
    check("R1 flags", {22'd0, data_end, block_end, rx_active, rx_empty, rx_avail,
          rx_full, tx_active, tx_empty, tx_avail, tx_full}, 32'd0);
    check("R1 half flags", {30'd0, rx_half_full, tx_half_empty}, 32'd0);
    check("R1 handshakes", {28'd0, card_rd_ready, card_wr_valid, push_ready, pop_err}, 32'd0);
    check("R1 pop data", pop_data, 32'd0);

    for (int len = 1; len <= 9; len++) rx_run(len);
    rx_run(33);
    for (int len = 1; len <= 9; len++) tx_run(len);
    tx_run(13);

    // R9 receive level sweep, R3 back-pressure, R12 empty pop
    base = rx_idx;
    do_start(1'b1, 68);
    check("R9 rx empty at 0", {27'd0, rx_active, rx_empty, rx_avail, rx_half_full, rx_full}, 32'b11000);
    for (int k = 1; k <= 16; k++) begin
      card_rd_valid = 1'b1;
      repeat (4) @(negedge clk);
      card_rd_valid = 1'b0;
      check("R9 rx flags", {27'd0, rx_active, rx_empty, rx_avail, rx_half_full, rx_full},
            {27'd0, 1'b1, 1'b0, 1'b1, (k >= 8) ? 1'b1 : 1'b0, (k == 16) ? 1'b1 : 1'b0});
      check("R9 tx flags hidden", {27'd0, tx_active, tx_empty, tx_avail, tx_half_empty, tx_full}, 32'd0);
    end
    card_rd_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R3 stall when full", 32'(card_rd_ready), 32'd0);
    check("R3 count frozen", 32'(byte_count), 32'd4);
    pop_word("R12 head word", rx_word(base, 0, 68));
    wait_zero();
    @(negedge clk);
    card_rd_valid = 1'b0;
    for (int j = 1; j <= 16; j++) pop_word("R3 drained word", rx_word(base, j, 68));
    @(negedge clk);
    check("R8 idle after rx drain", 32'(busy), 32'd0);
    check("R12 empty pop data", pop_data, 32'd0);
    pop_req = 1'b1;
    @(negedge clk);
    pop_req = 1'b0;
    check("R12 error raised", 32'(pop_err), 32'd1);
    repeat (3) @(negedge clk);
    check("R12 error sticky", 32'(pop_err), 32'd1);

    // R9 transmit level sweep, R11 push rules, R2 busy start, R12 tx pop
    base = tx_n;
    do_start(1'b0, 64);
    check("R2 start clears error", 32'(pop_err), 32'd0);
    check("R9 tx empty at 0", {27'd0, tx_active, tx_empty, tx_avail, tx_half_empty, tx_full}, 32'b11010);
    for (int k = 1; k <= 16; k++) begin
      push_word(tx_word(base + k - 1));
      check("R9 tx flags", {27'd0, tx_active, tx_empty, tx_avail, tx_half_empty, tx_full},
            {27'd0, 1'b1, 1'b0, 1'b1, (k <= 8) ? 1'b1 : 1'b0, (k == 16) ? 1'b1 : 1'b0});
      check("R9 rx flags hidden", {27'd0, rx_active, rx_empty, rx_avail, rx_half_full, rx_full}, 32'd0);
    end
    check("R11 no ready when full", 32'(push_ready), 32'd0);
    push_valid = 1'b1; push_data = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    push_valid = 1'b0;
    pop_req = 1'b1;
    @(negedge clk);
    pop_req = 1'b0;
    check("R12 tx pop ignored", {30'd0, tx_full, pop_err}, 32'b10);
    do_start(1'b1, 5);
    check("R2 busy start ignored count", 32'(byte_count), 32'd64);
    check("R2 busy start ignored dir", 32'(tx_active), 32'd1);
    card_wr_ready = 1'b1;
    wait_zero();
    repeat (3) @(negedge clk);
    card_wr_ready = 1'b0;
    check("R11 refused push ignored", 32'(tx_n - base), 32'd64);
    for (int k = 0; k < 64; k++)
      check("R5 sweep byte", 32'(tx_log[base + k]), 32'(tx_word(base + k / 4) >> (8 * (k % 4))) & 32'hFF);
    check("R8 idle after tx", 32'(busy), 32'd0);

    // zero-length transfer
    do_start(1'b1, 0);
    check("R2 zero length busy", 32'(busy), 32'd1);
    check("R7 flags cleared by start", {30'd0, data_end, block_end}, 32'd0);
    @(negedge clk);
    check("R8 zero length off", 32'(busy), 32'd0);
    check("R7 zero length end", {30'd0, data_end, block_end}, 32'b11);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule